// File: doc/BRIEF.md
# Reservation-Table Greedy Initiation Controller

This block decides, cycle by cycle, whether a new operation may start in a shared non-linear pipeline whose stage usage is given by a reservation table. Software or a neighbouring block writes the table one stage row at a time. Each row is a bit mask over the time slots in which that stage is busy. From the table, the block forms the initial collision vector. Bit n of this vector marks latency n as forbidden, because some stage would then be claimed twice in the same slot.

At run time the block keeps a collision state register. The register shifts one position toward bit 0 on every clock. On every accepted start, the vector is merged into it. A pending request is granted in the first cycle in which bit 0 of the state is clear, which is the greedy policy. The block also reports the current state, the derived vector, and a saturating count of cycles since the last start, so that the latency of each start can be seen on the outputs.

The requester keeps `req` high until `accept` is seen. `accept` is combinational in the cycle of the grant.

Top module: `coll_vec_initiator`

## Requirements
- R1: For n of 1 or more, bit n of `colVector` is 1 exactly when some table row has marks in two slots i and i+n. Slot k of a row is bit k of the written `tblData`, and bit n of the vector stands for latency n.
- R2: Bit 0 of `colVector` is 1 for every table, including an empty one.
- R3: In a cycle with `accept` high, the next `colState` is (`colState` OR `colVector`) shifted right by one with a 0 entering at the top.
- R4: In a cycle with neither `accept` nor `tblWe` high, the next `colState` is `colState` shifted right by one with zero fill.
- R5: `accept` is never high while bit 0 of `colState` is 1.
- R6: `accept` is high in every cycle in which `req` is high, bit 0 of `colState` is 0 and `tblWe` is low.
- R7: While `tblWe` is high, `accept` is low. In the following cycle, `colState` and `latency` are 0 and `colVector` reflects the newly written row.
- R8: `latency` is 1 in the cycle after an accept. Otherwise it rises by one per cycle and saturates at its all-ones value.
- R9: A request held high through busy cycles is granted in the first free cycle. For a table with vector 110011 (bits 5 down to 0), a continuous request sees start latencies alternating 2 and 6.
- R10: After reset the table is empty, `colState` and `latency` are 0, and `colVector` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tblWe | input | 1 | Write one reservation-table row this cycle |
| tblRow | input | ROW_W | Stage row selected for the write |
| tblData | input | NUM_SLOTS | Busy-slot mask of the row, bit k = slot k |
| req | input | 1 | New operation waiting to start |
| accept | output | 1 | Start granted this cycle |
| colState | output | NUM_SLOTS | Current collision state, bit 0 = blocked now |
| colVector | output | NUM_SLOTS | Initial collision vector derived from the table |
| latency | output | CNT_W | Cycles since the last start, saturating |

## Verification
The bench uses the default build: three stage rows, six time slots and an eight-bit latency counter. With six slots the bench can use the table whose vector is 110011, which gives the alternating 2 and 6 greedy cycle. It can also use a fully busy row, which forces a start only every sixth cycle, and an empty table, which grants every cycle. The eight-bit counter saturates at 255 in a few hundred idle cycles, so the bench reaches that bound directly. The bench also reloads the table while the state is non-zero, and it drops the request during free cycles to check plain shifting.

// File: rtl/cvi_pkg.sv
package cvi_pkg;
  typedef struct packed {
    logic writeRow;
    logic clearState;
    logic initiate;
  } cviStrobe_t;
endpackage

// File: rtl/cvi_ctrl.sv
module cvi_ctrl
  import cvi_pkg::*;
(
  input  logic       req,
  input  logic       tblWe,
  input  logic       stateBit0,
  output logic       accept,
  output cviStrobe_t strobe
);
  always_comb begin
    strobe.writeRow   = tblWe;
    strobe.clearState = tblWe;
    strobe.initiate   = req && !tblWe && !stateBit0;
    accept            = strobe.initiate;
  end
endmodule

// File: rtl/cvi_dpath.sv
module cvi_dpath
  import cvi_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int NUM_SLOTS  = 6,
  parameter int CNT_W      = 8,
  localparam int ROW_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  cviStrobe_t           strobe,
  input  logic [ROW_W-1:0]     tblRow,
  input  logic [NUM_SLOTS-1:0] tblData,
  output logic [NUM_SLOTS-1:0] colState,
  output logic [NUM_SLOTS-1:0] colVector,
  output logic [CNT_W-1:0]     latency
);
  localparam logic [CNT_W-1:0] LAT_MAX = {CNT_W{1'b1}};

  logic [NUM_SLOTS-1:0] rowMem [NUM_STAGES];
  logic [NUM_SLOTS-1:0] stateQ;
  logic [CNT_W-1:0]     latQ;

  // Table storage, one row per stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_STAGES; r++) rowMem[r] <= '0;
    end else if (strobe.writeRow && (int'(tblRow) < NUM_STAGES)) begin
      rowMem[tblRow] <= tblData;
    end
  end

  // Forbidden latency d: some row busy at slots i and i+d
  assign colVector[0] = 1'b1;
  for (genvar d = 1; d < NUM_SLOTS; d++) begin : g_dist
    logic pairHit;
    always_comb begin
      pairHit = 1'b0;
      for (int r = 0; r < NUM_STAGES; r++)
        for (int i = 0; i + d < NUM_SLOTS; i++)
          pairHit = pairHit | (rowMem[r][i] & rowMem[r][i+d]);
    end
    assign colVector[d] = pairHit;
  end

  // Collision state: merge on start, then advance one slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stateQ <= '0;
    else if (strobe.clearState) stateQ <= '0;
    else if (strobe.initiate)   stateQ <= (stateQ | colVector) >> 1;
    else                        stateQ <= stateQ >> 1;
  end

  // Cycles since last start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latQ <= '0;
    else if (strobe.clearState) latQ <= '0;
    else if (strobe.initiate)   latQ <= CNT_W'(1);
    else if (latQ != LAT_MAX)   latQ <= latQ + CNT_W'(1);
  end

  assign colState = stateQ;
  assign latency  = latQ;
endmodule

// File: rtl/coll_vec_initiator.sv
module coll_vec_initiator
  import cvi_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int NUM_SLOTS  = 6,
  parameter int CNT_W      = 8,
  localparam int ROW_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tblWe,
  input  logic [ROW_W-1:0]     tblRow,
  input  logic [NUM_SLOTS-1:0] tblData,
  input  logic                 req,
  output logic                 accept,
  output logic [NUM_SLOTS-1:0] colState,
  output logic [NUM_SLOTS-1:0] colVector,
  output logic [CNT_W-1:0]     latency
);
  cviStrobe_t strobe;

  cvi_ctrl u_ctrl (
    .req       (req),
    .tblWe     (tblWe),
    .stateBit0 (colState[0]),
    .accept    (accept),
    .strobe    (strobe)
  );

  cvi_dpath #(
    .NUM_STAGES (NUM_STAGES),
    .NUM_SLOTS  (NUM_SLOTS),
    .CNT_W      (CNT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tblRow    (tblRow),
    .tblData   (tblData),
    .colState  (colState),
    .colVector (colVector),
    .latency   (latency)
  );
endmodule

// File: rtl/cvi_checker.sv
module cvi_checker #(
  parameter int NUM_SLOTS = 6,
  parameter int CNT_W     = 8
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 tblWe,
  input logic                 req,
  input logic                 accept,
  input logic [NUM_SLOTS-1:0] colState,
  input logic [NUM_SLOTS-1:0] colVector,
  input logic [CNT_W-1:0]     latency
);
  a_r3_merge_shift: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> colState == (($past(colState) | $past(colVector)) >> 1));

  a_r4_idle_shift: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && !tblWe) |=> colState == ($past(colState) >> 1));

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    colState[0] |-> !accept);

  a_r6_greedy_grant: assert property (@(posedge clk) disable iff (!rstN)
    (req && !colState[0] && !tblWe) |-> accept);

  a_r7_load_holds: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |-> !accept);

  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |=> (colState == '0 && latency == '0));

  a_r8_latency_restart: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> latency == CNT_W'(1));
endmodule

bind coll_vec_initiator cvi_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tblWe     (tblWe),
  .req       (req),
  .accept    (accept),
  .colState  (colState),
  .colVector (colVector),
  .latency   (latency)
);

// File: tb/coll_vec_initiator_tb.sv
`timescale 1ns/1ps
module coll_vec_initiator_tb;
  localparam int STAGES = 3;
  localparam int SLOTS  = 6;
  localparam int CW     = 8;
  localparam int RW     = 2;

  // {row2, row1, row0, expected vector}
  localparam logic [23:0] VECS [5] = '{
    24'b010001_000110_100001_110011,
    24'b001000_000010_000101_000101,
    24'b000000_000000_111111_111111,
    24'b000000_000000_000000_000001,
    24'b000000_101001_000000_101101
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tblWe = 1'b0;
  logic [RW-1:0] tblRow = '0;
  logic [SLOTS-1:0] tblData = '0;
  logic req = 1'b0;
  logic accept;
  logic [SLOTS-1:0] colState, colVector;
  logic [CW-1:0] latency;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [SLOTS-1:0] mS, mIcv;
  int mLat;
  int accLat [16];
  int nAcc;

  always #2 clk = ~clk;

  coll_vec_initiator #(.NUM_STAGES(STAGES), .NUM_SLOTS(SLOTS), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblRow(tblRow), .tblData(tblData),
    .req(req), .accept(accept), .colState(colState), .colVector(colVector),
    .latency(latency)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a negedge: drive req, check, then advance one cycle
  task automatic step(input logic r);
    logic expAcc;
    req = r;
    #0.5;
    expAcc = r && !mS[0];
    chk("R5 R6 accept", 32'(accept), 32'(expAcc));
    chk("R3 R4 state", 32'(colState), 32'(mS));
    chk("R8 latency", 32'(latency), 32'(mLat));
    if (accept && nAcc < 16) begin accLat[nAcc] = int'(latency); nAcc++; end
    @(posedge clk);
    if (expAcc) begin mS = (mS | mIcv) >> 1; mLat = 1; end
    else begin mS = mS >> 1; if (mLat < 255) mLat++; end
    @(negedge clk);
  endtask

  task automatic loadTbl(input logic [17:0] t, input logic [SLOTS-1:0] icv);
    for (int r = 0; r < STAGES; r++) begin
      tblWe = 1'b1; tblRow = RW'(r); tblData = t[r*SLOTS +: SLOTS]; req = 1'b1;
      #0.5;
      chk("R7 accept during load", 32'(accept), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    tblWe = 1'b0;
    #0.5;
    chk("R1 R2 vector", 32'(colVector), 32'(icv));
    chk("R7 state cleared", 32'(colState), 32'd0);
    chk("R7 latency cleared", 32'(latency), 32'd0);
    mS = '0; mLat = 0; mIcv = icv; nAcc = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R10 reset state
    chk("R10 state", 32'(colState), 32'd0);
    chk("R10 vector", 32'(colVector), 32'd1);
    chk("R10 latency", 32'(latency), 32'd0);
    chk("R10 no request", 32'(accept), 32'd0);
    @(negedge clk);

    // Table walk with a continuous request
    for (int k = 0; k < 5; k++) begin
      loadTbl(VECS[k][23:6], VECS[k][5:0]);
      for (int c = 0; c < 20; c++) step(1'b1);
      if (k == 0) begin
        // R9 greedy cycle for vector 110011
        chk("R9 first gap", 32'(accLat[1]), 32'd2);
        chk("R9 second gap", 32'(accLat[2]), 32'd6);
        chk("R9 third gap", 32'(accLat[3]), 32'd2);
      end
      if (k == 2) chk("R1 full row gap", 32'(accLat[1]), 32'd6);
    end

    // Request dropped in free cycles: plain shifting (R4), held request (R9)
    loadTbl(VECS[0][23:6], VECS[0][5:0]);
    step(1'b1); step(1'b1); step(1'b0); step(1'b0); step(1'b1);
    for (int c = 0; c < 8; c++) step(1'b1);

    // Reload while state is non-zero (R7)
    step(1'b1);
    loadTbl(VECS[1][23:6], VECS[1][5:0]);
    for (int c = 0; c < 6; c++) step(1'b1);

    // Latency saturation (R8)
    req = 1'b0;
    repeat (300) @(negedge clk);
    #0.5;
    chk("R8 saturate", 32'(latency), 32'd255);
    chk("R4 drained", 32'(colState), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule